// File: doc/BRIEF.md
# Block SEC-DED Check-Bit Generator

This block computes the 24 check bits of a single-error-correcting, double-error-detecting code that protects a 2048-bit block of memory, fed in as 256 bytes. The bytes are placed on a two-dimensional grid. The bit position inside a byte is the column. The byte's place in the block is the row. The check bits are parities over halves of that grid. Each byte is folded into running accumulators as it arrives, so no block buffer is needed.

A start pulse opens a block. After that, bytes marked valid are taken one per cycle, in index order from 0 to 255. On the cycle after the 256th accepted byte, a one-cycle done pulse is raised. From that cycle until the next start, the check word holds the finished code. The check word is suitable for storing beside the data. Syndrome decoding and correction belong to other blocks.

Top module: `secded_blk_gen`

## Requirements
- R1: After synchronous reset, `done` is 0 and `check_word` is all zeros.
- R2: A `start` pulse clears all accumulators and the byte index. From the next cycle `check_word` is 0. A byte presented in the same cycle as `start` is not taken.
- R3: A byte is taken only when `in_valid` is high and no `start` is present, and only after a `start` and before the block's 256th byte. Bytes outside that window leave `check_word` unchanged and raise no `done`.
- R4: `done` is high for exactly one cycle. That cycle is the one after the 256th accepted byte.
- R5: Bits 0..5 hold the column parities. The column vector C is the XOR of all bytes. Bit 2k is the XOR of C[i] over the i with bit k of i equal to 0, and bit 2k+1 covers the i with bit k equal to 1 (k = 0..2).
- R6: Bits 6..15 hold the low row parities. Let r[j] be the XOR of the eight bits of byte j. Bit 6+2k is the XOR of r[j] over the j with bit k of j equal to 0, and bit 7+2k covers the j with bit k equal to 1 (k = 0..4).
- R7: Bits 16..21 hold the high row parities. Each 32-byte group g = j[7:5] is folded to one bit G[g], the XOR of r[j] over that group. Bit 16+2m covers the G[g] with bit m of g equal to 0, and bit 17+2m covers those with bit m equal to 1 (m = 0..2).
- R8: Bit 22 is the XOR of all 2048 data bits.
- R9: Bit 23 is the XOR of bits 0..21.
- R10: When neither `start` nor `in_valid` is high, `check_word` keeps its value into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Opens a new block and clears the accumulators |
| in_valid | input | 1 | Qualifies `in_byte` |
| in_byte | input | 8 | Data byte, sent in index order |
| done | output | 1 | One-cycle pulse after the final byte |
| check_word | output | 24 | Check bits, packed as in R5 to R9 |

## Verification
The assertions assume that `start` is a pulse, one cycle long, and that each byte stays on `in_byte` only for the cycle in which `in_valid` is high. They also assume that bytes arrive in index order, with no skipped index. The stimulus drives each byte for a single cycle on the falling edge. Random idle gaps are placed between bytes. Every `start` is issued as a lone one-cycle pulse. The stray bytes sent before a start, after done, or together with start do not break these assumptions. They exercise the ignore window of R3.

// File: rtl/secded_blk_pkg.sv
package secded_blk_pkg;

    // Fixed block geometry
    localparam int BYTE_W    = 8;
    localparam int BLK_BYTES = 256;
    localparam int GRP_BYTES = 32;

    // Derived sizes
    localparam int IDX_W  = $clog2(BLK_BYTES);
    localparam int LO_W   = $clog2(GRP_BYTES);
    localparam int HI_W   = IDX_W - LO_W;
    localparam int NGRP   = 2 ** HI_W;
    localparam int COL_P  = 2 * $clog2(BYTE_W);
    localparam int LO_P   = 2 * LO_W;
    localparam int HI_P   = 2 * HI_W;
    localparam int ROW_P  = LO_P + HI_P;
    localparam int DATA_P = COL_P + ROW_P;
    localparam int CHK_W  = DATA_P + 2;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] col;
        logic [LO_P-1:0]   row_lo;
        logic [NGRP-1:0]   grp;
    } acc_state_t;

endpackage

// File: rtl/par_mask_reduce.sv
// Split-half parities of a vector: for each index bit k, output 2k is the
// XOR over entries whose index has bit k clear, output 2k+1 over bit k set.
module par_mask_reduce #(
    parameter int W  = 8,
    localparam int LW = $clog2(W)
) (
    input  logic [W-1:0]    vec,
    output logic [2*LW-1:0] par
);

    function automatic logic [W-1:0] half_mask(input int k, input bit hi);
        logic [W-1:0] m;
        for (int i = 0; i < W; i++) begin
            m[i] = (((i >> k) & 1) == int'(hi));
        end
        return m;
    endfunction

    for (genvar k = 0; k < LW; k++) begin : g_pair
        assign par[2*k]   = ^(vec & half_mask(k, 1'b0));
        assign par[2*k+1] = ^(vec & half_mask(k, 1'b1));
    end

endmodule

// File: rtl/row_toggle.sv
// Turns one row-parity bit and its index into toggle requests for the
// even/odd accumulator pairs, one pair per index bit.
module row_toggle #(
    parameter int IW = 5
) (
    input  logic [IW-1:0]   idx,
    input  logic            rbit,
    output logic [2*IW-1:0] tog
);

    for (genvar k = 0; k < IW; k++) begin : g_bit
        assign tog[2*k]   = rbit & ~idx[k];
        assign tog[2*k+1] = rbit &  idx[k];
    end

endmodule

// File: rtl/secded_blk_gen.sv
module secded_blk_gen
    import secded_blk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              done,
    output logic [CHK_W-1:0]  check_word
);

    acc_state_t s_d, s_q;

    logic              take;
    logic              row_bit;
    logic [LO_P-1:0]   lo_tog;
    logic [COL_P-1:0]  col_par;
    logic [HI_P-1:0]   hi_par;
    logic [DATA_P-1:0] data_par;
    logic              busy_q;

    assign take    = s_q.busy & in_valid & ~start;
    assign row_bit = ^in_byte;
    assign busy_q  = s_q.busy;

    row_toggle #(.IW(LO_W)) i_row_toggle (
        .idx  (s_q.idx[LO_W-1:0]),
        .rbit (row_bit),
        .tog  (lo_tog)
    );

    par_mask_reduce #(.W(BYTE_W)) i_col_reduce (
        .vec (s_q.col),
        .par (col_par)
    );

    par_mask_reduce #(.W(NGRP)) i_grp_reduce (
        .vec (s_q.grp),
        .par (hi_par)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (start) begin
            s_d      = '0;
            s_d.busy = 1'b1;
        end else if (take) begin
            s_d.col    = s_q.col ^ in_byte;
            s_d.row_lo = s_q.row_lo ^ lo_tog;
            s_d.grp[s_q.idx[IDX_W-1:LO_W]] = s_q.grp[s_q.idx[IDX_W-1:LO_W]] ^ row_bit;
            s_d.idx    = s_q.idx + 1'b1;
            if (s_q.idx == IDX_W'(BLK_BYTES - 1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign data_par   = {hi_par, s_q.row_lo, col_par};
    assign check_word = {^data_par, ^s_q.col, data_par};
    assign done       = s_q.done;

endmodule

// File: rtl/secded_blk_chk.sv
module secded_blk_chk
    import secded_blk_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             in_valid,
    input logic             busy,
    input logic             done,
    input logic [CHK_W-1:0] check_word
);

    logic [IDX_W:0] seen;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            seen <= '0;
        end else if (busy && in_valid) begin
            seen <= seen + 1'b1;
        end
    end

    localparam int HI0 = COL_P + LO_P;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R4
    AST_DONE_COUNT: assert property (@(posedge clk) disable iff (rst)
        done |-> (seen == (IDX_W+1)'(BLK_BYTES))); // R4
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start |=> (check_word == '0 && !done)); // R2
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!start && !in_valid) |=> $stable(check_word)); // R10
    AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (!start && !busy) |=> ($stable(check_word) && !done)); // R3
    AST_COL_HALVES: assert property (@(posedge clk) disable iff (rst)
        (check_word[0] ^ check_word[1]) == (check_word[2] ^ check_word[3])); // R5
    AST_ROW_HALVES: assert property (@(posedge clk) disable iff (rst)
        (check_word[COL_P] ^ check_word[COL_P+1]) == (check_word[HI0] ^ check_word[HI0+1])); // R7
    AST_TOTAL_MATCH: assert property (@(posedge clk) disable iff (rst)
        check_word[DATA_P] == (check_word[COL_P+2] ^ check_word[COL_P+3])); // R8

endmodule

bind secded_blk_gen secded_blk_chk i_secded_blk_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .in_valid   (in_valid),
    .busy       (busy_q),
    .done       (done),
    .check_word (check_word)
);

// File: tb/test_secded_blk_gen.sv
module test_secded_blk_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        done;
    logic [23:0] check_word;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] blk [256];

    always #2.5 clk = ~clk;

    secded_blk_gen i_secded_blk_gen (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .in_valid   (in_valid),
        .in_byte    (in_byte),
        .done       (done),
        .check_word (check_word)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference built straight from the mask constants
    function automatic logic [23:0] ref_check();
        logic [7:0]  col = '0;
        logic [255:0] rp;
        logic [7:0]  g = '0;
        logic [5:0]  yp, xh;
        logic [9:0]  xl;
        logic [7:0]  m8 [6];
        logic [31:0] m32 [10];
        logic [23:0] r;
        m8 = '{8'h55, 8'haa, 8'h33, 8'hcc, 8'h0f, 8'hf0};
        m32 = '{32'h55555555, 32'haaaaaaaa, 32'h33333333, 32'hcccccccc, 32'h0f0f0f0f,
                32'hf0f0f0f0, 32'h00ff00ff, 32'hff00ff00, 32'h0000ffff, 32'hffff0000};
        for (int j = 0; j < 256; j++) begin
            col   = col ^ blk[j];
            rp[j] = ^blk[j];
        end
        for (int q = 0; q < 8; q++) g[q] = ^rp[q*32 +: 32];
        for (int t = 0; t < 6; t++) begin
            yp[t] = ^(col & m8[t]);
            xh[t] = ^(g & m8[t]);
        end
        for (int t = 0; t < 10; t++) begin
            xl[t] = 1'b0;
            for (int q = 0; q < 8; q++) xl[t] = xl[t] ^ (^(rp[q*32 +: 32] & m32[t]));
        end
        r[21:0] = {xh, xl, yp};
        r[22]   = ^rp;
        r[23]   = ^r[21:0];
        return r;
    endfunction

    task automatic pulse_start(input logic with_byte);
        @(negedge clk);
        start    = 1'b1;
        in_valid = with_byte;
        in_byte  = 8'hA5;
        @(negedge clk);
        start    = 1'b0;
        in_valid = 1'b0;
        check("R2 cleared after start", {8'h0, check_word}, 32'h0);
    endtask

    task automatic run_block(input bit gaps, input string tag);
        logic [23:0] e;
        logic        early = 1'b0;
        e = ref_check();
        for (int i = 0; i < 256; i++) begin
            if (gaps && ($urandom % 4 == 0)) begin
                @(negedge clk);
                in_valid = 1'b0;
                repeat ($urandom % 3) @(negedge clk);
            end else begin
                @(negedge clk);
            end
            if (done) early = 1'b1;
            in_valid = 1'b1;
            in_byte  = blk[i];
        end
        @(negedge clk);
        in_valid = 1'b0;
        check({"R4 no early done ", tag}, {31'h0, early}, 32'h0);
        check({"R4 done after last ", tag}, {31'h0, done}, 32'h1);
        check({"R5 column bits ", tag}, {26'h0, check_word[5:0]}, {26'h0, e[5:0]});
        check({"R6 low row bits ", tag}, {22'h0, check_word[15:6]}, {22'h0, e[15:6]});
        check({"R7 high row bits ", tag}, {26'h0, check_word[21:16]}, {26'h0, e[21:16]});
        check({"R8 total parity ", tag}, {31'h0, check_word[22]}, {31'h0, e[22]});
        check({"R9 check parity ", tag}, {31'h0, check_word[23]}, {31'h0, e[23]});
        @(negedge clk);
        check({"R4 single cycle ", tag}, {31'h0, done}, 32'h0);
    endtask

    task automatic stray_bytes(input int n, input logic [23:0] keep, input string req);
        logic seen_done = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (done) seen_done = 1'b1;
            in_valid = 1'b1;
            in_byte  = 8'($urandom);
        end
        @(negedge clk);
        in_valid = 1'b0;
        if (done) seen_done = 1'b1;
        check({req, " value held"}, {8'h0, check_word}, {8'h0, keep});
        check({req, " no done"}, {31'h0, seen_done}, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [23:0] held;
        void'($urandom(32'h1F2E3D4C));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 done after reset", {31'h0, done}, 32'h0);
        check("R1 check after reset", {8'h0, check_word}, 32'h0);

        // R3: bytes before any start are ignored
        stray_bytes(6, 24'h0, "R3 pre-start");

        // all-zero block
        pulse_start(1'b0);
        for (int j = 0; j < 256; j++) blk[j] = 8'h00;
        run_block(1'b0, "zeros");

        // all-one block
        pulse_start(1'b0);
        for (int j = 0; j < 256; j++) blk[j] = 8'hFF;
        run_block(1'b0, "ones");

        // single set bit: byte 37, bit 4
        pulse_start(1'b0);
        for (int j = 0; j < 256; j++) blk[j] = 8'h00;
        blk[37] = 8'h10;
        run_block(1'b0, "single");

        // last byte only, highest bit
        pulse_start(1'b0);
        for (int j = 0; j < 256; j++) blk[j] = 8'h00;
        blk[255] = 8'h80;
        run_block(1'b1, "last");

        // random blocks with idle gaps
        for (int b = 0; b < 3; b++) begin
            pulse_start(1'b0);
            for (int j = 0; j < 256; j++) blk[j] = 8'($urandom);
            run_block(b != 0, "random");
        end

        // R3 and R10: bytes after done do not disturb the result
        held = check_word;
        stray_bytes(8, held, "R3 post-done");
        repeat (5) @(negedge clk);
        check("R10 idle hold", {8'h0, check_word}, {8'h0, held});

        // restart mid-block; a byte with start is dropped
        pulse_start(1'b0);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_byte  = 8'($urandom);
        end
        pulse_start(1'b1);
        for (int j = 0; j < 256; j++) blk[j] = 8'($urandom);
        run_block(1'b1, "restart");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule